// File: doc/BRIEF.md
# DRAM Bank Command Scheduler

This block sits in a memory partition between the request stream and the DRAM command pins. It holds up to a parameterised number of read and write requests, each naming a bank, a row and a column, and turns them into activate, column read, column write and precharge commands, at most one per cycle. Each bank keeps its own open row and its own timers, so banks work in parallel. Before issuing a command, the block checks the activate-to-column gap, the precharge-to-activate gap and the activate-to-activate gap of the target bank.

A policy input chooses between two disciplines. In strict-order mode only the oldest queued request may advance. In open-row-first mode the scheduler searches the whole queue for the oldest request that hits an already open row whose column timing is met, and serves that first. When no such request exists it falls back to the oldest request. A request is reported complete on a separate strobe, one cycle after its column command appears on the bus.

Top module: `dram_sched`

## Requirements
- R1: A request to a closed bank whose timers are satisfied gets an activate and then a column command no fewer than T_RCD cycles after the activate. With the defaults, completion is visible 5 clock edges after the edge that accepted the request.
- R2: A request to the open row of a bank gets a column command with no activate, and completion is visible 2 edges after acceptance.
- R3: A request to a bank that has a different row open gets a precharge, then an activate no fewer than T_RP cycles later, then the column command. An activate never goes to a bank whose row is open. With the defaults and all other timers met, completion is visible 8 edges after acceptance.
- R4: Two activates to the same bank are at least T_RC cycles apart. With the defaults, a row miss accepted on the cycle after the previous access to that bank completed finishes 9 edges after acceptance.
- R5: Each bank keeps its own open row: traffic to one bank does not close or change the row open in another.
- R6: With policy = 0, requests complete strictly in acceptance order.
- R7: With policy = 1, the oldest queued request that hits an open row with its column timing met goes first. Otherwise only the oldest request may issue, and if its command is not yet legal, no command issues.
- R8: req_ready is low while the queue holds DEPTH requests. A request held on req_valid while req_ready is low is accepted later and is not lost.
- R9: done pulses for one cycle, on the cycle after a column command appears on the bus. It carries that request's bank, row, column and write flag.
- R10: After reset the queue is empty and every bank is closed with its timers satisfied. cmd is 0, done is 0 and req_ready is 1.
- R11: Command encoding on cmd: 0 none, 1 activate, 2 column read, 3 column write, 4 precharge. cmd_addr carries the row for an activate and the zero-extended column for a column command.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| policy | input | 1 | 0 strict order, 1 open-row-first |
| req_valid | input | 1 | Request offered |
| req_ready | output | 1 | Queue has room; request taken on this edge |
| req_write | input | 1 | 1 write, 0 read |
| req_bank | input | BANK_W | Target bank |
| req_row | input | ROW_W | Target row |
| req_col | input | COL_W | Target column |
| cmd | output | 3 | Registered command code |
| cmd_bank | output | BANK_W | Bank of the command |
| cmd_addr | output | max(ROW_W,COL_W) | Row or column of the command |
| done | output | 1 | Completion strobe |
| done_write | output | 1 | Completed request was a write |
| done_bank | output | BANK_W | Bank of completed request |
| done_row | output | ROW_W | Row of completed request |
| done_col | output | COL_W | Column of completed request |

## Verification
A queued request needs one edge to enter the queue and one more to place its first command on the registered bus. The column command reaches the bus T_RCD edges after the activate, or T_RP more after a precharge, and done follows one edge after the column command. This gives totals of 2, 5, 8 or 9 edges for a hit, a closed bank, a miss, and a miss held back by the activate-to-activate gap. The bench counts edges from the accepting edge and compares done at the falling edge after each candidate edge. A bus monitor timestamps every command by falling edge and expects done exactly one edge after each column command.

// File: rtl/dram_sched_pkg.sv
package dram_sched_pkg;
  typedef enum logic [2:0] {
    CMD_NOP = 3'd0,
    CMD_ACT = 3'd1,
    CMD_RD  = 3'd2,
    CMD_WR  = 3'd3,
    CMD_PRE = 3'd4
  } cmd_e;
endpackage

// File: rtl/ds_queue.sv
// Age-ordered request queue: slot 0 is the oldest, removal collapses upward slots.
module ds_queue #(
  parameter int DEPTH = 8,
  parameter int ENT_W = 17,
  localparam int IDX_W = $clog2(DEPTH),
  localparam int CNT_W = $clog2(DEPTH + 1)
) (
  input  logic                             clk,
  input  logic                             rst,
  input  logic                             push,
  input  logic [ENT_W-1:0]                 push_ent,
  input  logic                             pop,
  input  logic [IDX_W-1:0]                 pop_idx,
  output logic [DEPTH-1:0][ENT_W-1:0]      ent_q,
  output logic [CNT_W-1:0]                 count,
  output logic                             full
);
  logic [ENT_W-1:0] upper [DEPTH];
  logic [CNT_W-1:0] wr_pos;

  generate
    for (genvar i = 0; i < DEPTH; i++) begin : g_up
      if (i < DEPTH - 1) begin : g_mid
        assign upper[i] = ent_q[i+1];
      end else begin : g_last
        assign upper[i] = '0;
      end
    end
  endgenerate

  assign wr_pos = count - CNT_W'(pop);
  assign full   = (count == CNT_W'(DEPTH));

  always_ff @(posedge clk) begin
    if (rst) begin
      ent_q <= '0;
      count <= '0;
    end else begin
      for (int i = 0; i < DEPTH; i++) begin
        if (push && (CNT_W'(i) == wr_pos))
          ent_q[i] <= push_ent;
        else if (pop && (i >= int'(pop_idx)))
          ent_q[i] <= upper[i];
      end
      count <= count + CNT_W'(push) - CNT_W'(pop);
    end
  end

  assert_no_overflow_R8: assert property (@(posedge clk) disable iff (rst)
    push |-> (count < CNT_W'(DEPTH)));
  assert_pop_in_range_R6: assert property (@(posedge clk) disable iff (rst)
    pop |-> (CNT_W'(pop_idx) < count));
endmodule

// File: rtl/ds_bank.sv
// Per-bank open-row state and timing counters.
module ds_bank #(
  parameter int ROW_W = 8,
  parameter int T_RP  = 3,
  parameter int T_RCD = 3,
  parameter int T_RC  = 10,
  localparam int SAT_A = (T_RC > T_RCD) ? T_RC : T_RCD,
  localparam int SAT   = (SAT_A > T_RP) ? SAT_A : T_RP,
  localparam int CW    = $clog2(SAT + 1)
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             do_act,
  input  logic             do_pre,
  input  logic             do_col,
  input  logic [ROW_W-1:0] act_row,
  output logic             is_open,
  output logic [ROW_W-1:0] open_row,
  output logic             act_ok,
  output logic             col_ok
);
  logic [CW-1:0] since_act;
  logic [CW-1:0] since_pre;

  always_ff @(posedge clk) begin
    if (rst) begin
      is_open   <= 1'b0;
      open_row  <= '0;
      since_act <= CW'(SAT);
      since_pre <= CW'(SAT);
    end else begin
      if (do_act) begin
        is_open   <= 1'b1;
        open_row  <= act_row;
        since_act <= CW'(1);
      end else if (since_act < CW'(SAT)) begin
        since_act <= since_act + 1'b1;
      end
      if (do_pre) begin
        is_open   <= 1'b0;
        since_pre <= CW'(1);
      end else if (since_pre < CW'(SAT)) begin
        since_pre <= since_pre + 1'b1;
      end
    end
  end

  assign act_ok = !is_open && (since_act >= CW'(T_RC)) && (since_pre >= CW'(T_RP));
  assign col_ok = is_open && (since_act >= CW'(T_RCD));

  assert_rcd_gap_R1: assert property (@(posedge clk) disable iff (rst)
    do_col |-> (is_open && since_act >= CW'(T_RCD)));
  assert_rp_gap_R3: assert property (@(posedge clk) disable iff (rst)
    do_act |-> (since_pre >= CW'(T_RP)));
  assert_act_closed_R3: assert property (@(posedge clk) disable iff (rst)
    do_act |-> !is_open);
  assert_rc_gap_R4: assert property (@(posedge clk) disable iff (rst)
    do_act |-> (since_act >= CW'(T_RC)));
  assert_pre_open_R3: assert property (@(posedge clk) disable iff (rst)
    do_pre |-> is_open);
endmodule

// File: rtl/ds_picker.sv
// Chooses the single command of this cycle from queue and bank state.
module ds_picker
  import dram_sched_pkg::*;
#(
  parameter int DEPTH  = 8,
  parameter int NBANK  = 4,
  parameter int ROW_W  = 8,
  parameter int COL_W  = 6,
  localparam int BANK_W = $clog2(NBANK),
  localparam int ENT_W  = 1 + BANK_W + ROW_W + COL_W,
  localparam int IDX_W  = $clog2(DEPTH),
  localparam int CNT_W  = $clog2(DEPTH + 1)
) (
  input  logic                        policy,
  input  logic [DEPTH-1:0][ENT_W-1:0] ent_q,
  input  logic [CNT_W-1:0]            count,
  input  logic [NBANK-1:0]            bank_open,
  input  logic [ROW_W-1:0]            bank_row [NBANK],
  input  logic [NBANK-1:0]            act_ok,
  input  logic [NBANK-1:0]            col_ok,
  output cmd_e                        issue_cmd,
  output logic [BANK_W-1:0]           issue_bank,
  output logic [ROW_W-1:0]            issue_row,
  output logic [COL_W-1:0]            issue_col,
  output logic                        pop,
  output logic [IDX_W-1:0]            pop_idx
);
  logic [DEPTH-1:0] hit_rdy;
  logic             found;
  logic [IDX_W-1:0] sel;
  logic [ENT_W-1:0] pick;
  logic [BANK_W-1:0] pb;
  logic [ROW_W-1:0]  pr;

  always_comb begin
    for (int i = 0; i < DEPTH; i++) begin
      logic [BANK_W-1:0] b;
      logic [ROW_W-1:0]  r;
      b = ent_q[i][COL_W+ROW_W +: BANK_W];
      r = ent_q[i][COL_W +: ROW_W];
      hit_rdy[i] = (CNT_W'(i) < count) && bank_open[b] && (bank_row[b] == r) && col_ok[b];
    end
    found = 1'b0;
    sel   = '0;
    for (int i = DEPTH - 1; i >= 0; i--) begin
      if (hit_rdy[i]) begin
        found = 1'b1;
        sel   = IDX_W'(i);
      end
    end
  end

  always_comb begin
    issue_cmd = CMD_NOP;
    pop       = 1'b0;
    pop_idx   = '0;
    pick      = (policy && found) ? ent_q[sel] : ent_q[0];
    pb        = pick[COL_W+ROW_W +: BANK_W];
    pr        = pick[COL_W +: ROW_W];
    if (policy && found) begin
      issue_cmd = pick[ENT_W-1] ? CMD_WR : CMD_RD;
      pop       = 1'b1;
      pop_idx   = sel;
    end else if (count != '0) begin
      if (hit_rdy[0]) begin
        issue_cmd = pick[ENT_W-1] ? CMD_WR : CMD_RD;
        pop       = 1'b1;
      end else if (bank_open[pb] && (bank_row[pb] != pr)) begin
        issue_cmd = CMD_PRE;
      end else if (!bank_open[pb] && act_ok[pb]) begin
        issue_cmd = CMD_ACT;
      end
    end
    issue_bank = pb;
    issue_row  = pr;
    issue_col  = pick[COL_W-1:0];
  end
endmodule

// File: rtl/dram_sched.sv
module dram_sched
  import dram_sched_pkg::*;
#(
  parameter int NBANK = 4,
  parameter int ROW_W = 8,
  parameter int COL_W = 6,
  parameter int DEPTH = 8,
  parameter int T_RP  = 3,
  parameter int T_RCD = 3,
  parameter int T_RC  = 10,
  localparam int BANK_W = $clog2(NBANK),
  localparam int ADDR_W = (ROW_W > COL_W) ? ROW_W : COL_W,
  localparam int ENT_W  = 1 + BANK_W + ROW_W + COL_W,
  localparam int IDX_W  = $clog2(DEPTH),
  localparam int CNT_W  = $clog2(DEPTH + 1)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              policy,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic              req_write,
  input  logic [BANK_W-1:0] req_bank,
  input  logic [ROW_W-1:0]  req_row,
  input  logic [COL_W-1:0]  req_col,
  output logic [2:0]        cmd,
  output logic [BANK_W-1:0] cmd_bank,
  output logic [ADDR_W-1:0] cmd_addr,
  output logic              done,
  output logic              done_write,
  output logic [BANK_W-1:0] done_bank,
  output logic [ROW_W-1:0]  done_row,
  output logic [COL_W-1:0]  done_col
);
  logic                        push, pop, full;
  logic [IDX_W-1:0]            pop_idx;
  logic [DEPTH-1:0][ENT_W-1:0] ent_q;
  logic [CNT_W-1:0]            count;
  cmd_e                        issue_cmd;
  logic [BANK_W-1:0]           issue_bank;
  logic [ROW_W-1:0]            issue_row;
  logic [COL_W-1:0]            issue_col;
  logic [NBANK-1:0]            bank_open, act_ok, col_ok;
  logic [ROW_W-1:0]            bank_row [NBANK];
  logic [ROW_W-1:0]            cmd_row_q;

  assign req_ready = !full;
  assign push      = req_valid && !full;

  ds_queue #(.DEPTH(DEPTH), .ENT_W(ENT_W)) u_queue (
    .clk(clk), .rst(rst), .push(push),
    .push_ent({req_write, req_bank, req_row, req_col}),
    .pop(pop), .pop_idx(pop_idx), .ent_q(ent_q), .count(count), .full(full)
  );

  ds_picker #(.DEPTH(DEPTH), .NBANK(NBANK), .ROW_W(ROW_W), .COL_W(COL_W)) u_picker (
    .policy(policy), .ent_q(ent_q), .count(count),
    .bank_open(bank_open), .bank_row(bank_row), .act_ok(act_ok), .col_ok(col_ok),
    .issue_cmd(issue_cmd), .issue_bank(issue_bank), .issue_row(issue_row),
    .issue_col(issue_col), .pop(pop), .pop_idx(pop_idx)
  );

  generate
    for (genvar b = 0; b < NBANK; b++) begin : g_bank
      logic sel_b;
      assign sel_b = (issue_bank == BANK_W'(b));
      ds_bank #(.ROW_W(ROW_W), .T_RP(T_RP), .T_RCD(T_RCD), .T_RC(T_RC)) u_bank (
        .clk(clk), .rst(rst),
        .do_act(sel_b && issue_cmd == CMD_ACT),
        .do_pre(sel_b && issue_cmd == CMD_PRE),
        .do_col(sel_b && (issue_cmd == CMD_RD || issue_cmd == CMD_WR)),
        .act_row(issue_row),
        .is_open(bank_open[b]), .open_row(bank_row[b]),
        .act_ok(act_ok[b]), .col_ok(col_ok[b])
      );
    end
  endgenerate

  always_ff @(posedge clk) begin
    if (rst) begin
      cmd        <= CMD_NOP;
      cmd_bank   <= '0;
      cmd_addr   <= '0;
      cmd_row_q  <= '0;
      done       <= 1'b0;
      done_write <= 1'b0;
      done_bank  <= '0;
      done_row   <= '0;
      done_col   <= '0;
    end else begin
      cmd       <= issue_cmd;
      cmd_bank  <= issue_bank;
      cmd_row_q <= issue_row;
      case (issue_cmd)
        CMD_ACT:        cmd_addr <= ADDR_W'(issue_row);
        CMD_RD, CMD_WR: cmd_addr <= ADDR_W'(issue_col);
        default:        cmd_addr <= '0;
      endcase
      done       <= (cmd == CMD_RD) || (cmd == CMD_WR);
      done_write <= (cmd == CMD_WR);
      done_bank  <= cmd_bank;
      done_row   <= cmd_row_q;
      done_col   <= cmd_addr[COL_W-1:0];
    end
  end

  assert_done_follows_col_R9: assert property (@(posedge clk) disable iff (rst)
    (cmd == CMD_RD || cmd == CMD_WR) |=> (done && done_bank == $past(cmd_bank)));
  assert_done_single_R9: assert property (@(posedge clk) disable iff (rst)
    done |=> !done || $past(cmd == CMD_RD || cmd == CMD_WR));
endmodule

// File: tb/dram_sched_test.sv
module dram_sched_test;
  localparam int T_RP = 3, T_RCD = 3, T_RC = 10;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       policy = 1'b0;
  logic       req_valid = 1'b0, req_write = 1'b0;
  logic [1:0] req_bank = '0;
  logic [7:0] req_row = '0;
  logic [5:0] req_col = '0;
  logic       req_ready;
  logic [2:0] cmd;
  logic [1:0] cmd_bank;
  logic [7:0] cmd_addr;
  logic       done, done_write;
  logic [1:0] done_bank;
  logic [7:0] done_row;
  logic [5:0] done_col;

  int n_cmp = 0, n_bad = 0;
  int cyc = 0;
  int log_n = 0;
  logic [5:0] log_col [32];
  bit saw_full = 0;

  always #5 clk = ~clk;

  dram_sched uut (
    .clk(clk), .rst(rst), .policy(policy), .req_valid(req_valid), .req_ready(req_ready),
    .req_write(req_write), .req_bank(req_bank), .req_row(req_row), .req_col(req_col),
    .cmd(cmd), .cmd_bank(cmd_bank), .cmd_addr(cmd_addr), .done(done), .done_write(done_write),
    .done_bank(done_bank), .done_row(done_row), .done_col(done_col)
  );

  // Bus monitor: timing rules per bank and done one edge after each column command.
  int m_act [4];
  int m_pre [4];
  bit m_open [4];
  logic [7:0] m_row [4];
  bit pend = 0;
  logic pend_wr;
  logic [1:0] pend_bank;
  logic [7:0] pend_row;
  logic [5:0] pend_col;

  always @(negedge clk) begin
    cyc++;
    if (rst) begin
      for (int b = 0; b < 4; b++) begin
        m_act[b] = -100; m_pre[b] = -100; m_open[b] = 0; m_row[b] = '0;
      end
      pend = 0;
    end else begin
      if (pend) begin
        n_cmp++;
        if (!done || done_bank != pend_bank || done_row != pend_row ||
            done_col != pend_col || done_write != pend_wr) begin
          n_bad++;
          $display("FAIL R9 done=%0d b=%0d r=%0d c=%0d w=%0d expected 1 b=%0d r=%0d c=%0d w=%0d",
                   done, done_bank, done_row, done_col, done_write,
                   pend_bank, pend_row, pend_col, pend_wr);
        end
      end else if (done) begin
        n_cmp++; n_bad++;
        $display("FAIL R9 done=1 expected 0 (no column command before)");
      end
      pend = 0;
      if (done && log_n < 32) begin log_col[log_n] = done_col; log_n++; end
      case (cmd)
        3'd0: ;
        3'd1: begin
          n_cmp++;
          if (m_open[cmd_bank]) begin n_bad++; $display("FAIL R3 activate to open bank %0d, expected closed", cmd_bank); end
          if (cyc - m_pre[cmd_bank] < T_RP) begin n_bad++; $display("FAIL R3 pre-to-act gap %0d expected >= %0d", cyc - m_pre[cmd_bank], T_RP); end
          if (cyc - m_act[cmd_bank] < T_RC) begin n_bad++; $display("FAIL R4 act-to-act gap %0d expected >= %0d", cyc - m_act[cmd_bank], T_RC); end
          m_open[cmd_bank] = 1; m_row[cmd_bank] = cmd_addr; m_act[cmd_bank] = cyc;
        end
        3'd2, 3'd3: begin
          n_cmp++;
          if (!m_open[cmd_bank] || cyc - m_act[cmd_bank] < T_RCD) begin
            n_bad++;
            $display("FAIL R1 column to bank %0d open=%0d gap %0d expected open and gap >= %0d",
                     cmd_bank, m_open[cmd_bank], cyc - m_act[cmd_bank], T_RCD);
          end
          pend = 1; pend_wr = (cmd == 3'd3); pend_bank = cmd_bank;
          pend_row = m_row[cmd_bank]; pend_col = cmd_addr[5:0];
        end
        3'd4: begin
          n_cmp++;
          if (!m_open[cmd_bank]) begin n_bad++; $display("FAIL R3 precharge of closed bank %0d", cmd_bank); end
          m_open[cmd_bank] = 0; m_pre[cmd_bank] = cyc;
        end
        default: begin
          n_cmp++; n_bad++;
          $display("FAIL R11 cmd=%0d expected code 0..4", cmd);
        end
      endcase
    end
  end

  // {write, bank, row, col, expected edges from acceptance to done}
  localparam logic [20:0] VEC [8] = '{
    {1'b0, 2'd0, 8'd10, 6'd1, 4'd5},  // closed bank          R1
    {1'b1, 2'd0, 8'd10, 6'd2, 4'd2},  // open-row hit         R2
    {1'b0, 2'd1, 8'd5,  6'd3, 4'd5},  // other bank closed    R1
    {1'b0, 2'd1, 8'd6,  6'd4, 4'd9},  // miss held by T_RC    R4
    {1'b1, 2'd1, 8'd6,  6'd5, 4'd2},  // hit                  R2
    {1'b0, 2'd0, 8'd11, 6'd6, 4'd8},  // miss, row10 kept     R3
    {1'b0, 2'd0, 8'd11, 6'd7, 4'd2},  // hit                  R2
    {1'b1, 2'd3, 8'd0,  6'd0, 4'd5}   // closed bank          R1
  };

  function automatic string tag_of(int lat);
    case (lat)
      2: return "R2";
      5: return "R1";
      8: return "R3";
      default: return "R4";
    endcase
  endfunction

  task automatic do_reset();
    req_valid = 0;
    rst = 1;
    repeat (3) @(negedge clk);
    rst = 0;
  endtask

  task automatic push_req(input logic w, input logic [1:0] b, input logic [7:0] r, input logic [5:0] c);
    req_valid = 1; req_write = w; req_bank = b; req_row = r; req_col = c;
    while (!req_ready) begin saw_full = 1; @(negedge clk); end
    @(posedge clk);
    @(negedge clk);
    req_valid = 0;
  endtask

  task automatic wait_latency(output int k);
    k = 0;
    while (!done && k < 40) begin @(negedge clk); k++; end
  endtask

  task automatic wait_log(input int n);
    for (int k = 0; k < 600 && log_n < n; k++) @(negedge clk);
  endtask

  task automatic check_order(input string tag, input logic [5:0] e0, input logic [5:0] e1, input logic [5:0] e2);
    logic [5:0] exp_c [3];
    exp_c[0] = e0; exp_c[1] = e1; exp_c[2] = e2;
    for (int i = 0; i < 3; i++) begin
      n_cmp++;
      if (log_n <= i || log_col[i] != exp_c[i]) begin
        n_bad++;
        $display("FAIL %s completion %0d col=%0d expected %0d", tag, i, log_col[i], exp_c[i]);
      end
    end
  endtask

  task automatic ordering_run(input logic pol);
    do_reset();
    policy = pol;
    push_req(0, 2'd0, 8'd1, 6'd9);          // open row 1 in bank 0
    wait_log(1);
    repeat (14) @(negedge clk);
    log_n = 0;
    push_req(0, 2'd1, 8'd4, 6'd20);         // closed bank, waits on T_RCD
    push_req(0, 2'd0, 8'd2, 6'd21);         // miss in bank 0
    push_req(0, 2'd0, 8'd1, 6'd22);         // hit in bank 0
    wait_log(3);
  endtask

  initial begin : watchdog
    repeat (20000) @(posedge clk);
    n_bad++;
    $display("FAIL watchdog expired");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin : main
    int k;
    repeat (3) @(negedge clk);
    rst = 0;
    // R10: reset state
    n_cmp++;
    if (req_ready !== 1'b1 || cmd !== 3'd0 || done !== 1'b0) begin
      n_bad++;
      $display("FAIL R10 ready=%0d cmd=%0d done=%0d expected 1 0 0", req_ready, cmd, done);
    end

    // Vector table, one request at a time, strict order mode
    policy = 0;
    for (int v = 0; v < 8; v++) begin
      push_req(VEC[v][20], VEC[v][19:18], VEC[v][17:10], VEC[v][9:4]);
      wait_latency(k);
      n_cmp++;
      if (k != int'(VEC[v][3:0]) || done_col != VEC[v][9:4] || done_row != VEC[v][17:10] ||
          done_bank != VEC[v][19:18] || done_write != VEC[v][20]) begin
        n_bad++;
        $display("FAIL %s vector %0d latency=%0d col=%0d expected latency=%0d col=%0d",
                 tag_of(int'(VEC[v][3:0])), v, k, done_col, VEC[v][3:0], VEC[v][9:4]);
      end
    end

    // R5: bank 1 still has row 6 open after bank 0 and bank 3 traffic
    push_req(0, 2'd1, 8'd6, 6'd30);
    wait_latency(k);
    n_cmp++;
    if (k != 2 || done_col != 6'd30) begin
      n_bad++;
      $display("FAIL R5 latency=%0d col=%0d expected 2 col=30", k, done_col);
    end

    // R7: open-row-first lets the younger hit overtake
    ordering_run(1'b1);
    check_order("R7", 6'd22, 6'd20, 6'd21);

    // R6: strict order keeps acceptance order for the same stimulus
    ordering_run(1'b0);
    check_order("R6", 6'd20, 6'd21, 6'd22);

    // R8: back-pressure with alternating rows in one bank; no request lost
    do_reset();
    policy = 0;
    log_n = 0;
    saw_full = 0;
    for (int i = 0; i < 12; i++) push_req(1'b0, 2'd2, 8'(i % 2), 6'(i));
    n_cmp++;
    if (!saw_full) begin n_bad++; $display("FAIL R8 req_ready never low, expected low when full"); end
    wait_log(12);
    for (int i = 0; i < 12; i++) begin
      n_cmp++;
      if (log_n <= i || log_col[i] != 6'(i)) begin
        n_bad++;
        $display("FAIL R8 completion %0d col=%0d expected %0d (R6 order)", i, log_col[i], i);
      end
    end

    repeat (4) @(negedge clk);
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule